// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

A controller for 32 general-purpose pins, attached to a simple 32-bit register bus. Software uses six registers to set, for each pin, whether it is an input or an output and whether it is open-drain. It also uses them to read and write pin levels, inspect and acknowledge latched pin events, mask those events, and choose whether a pin flags any change or only a falling edge. The interrupt line is the OR of all pending events that are not masked.

Input pins pass through a two-flop synchroniser. An edge detector then compares the synchronised level with its value one cycle earlier. Pins are numbered from the most significant register bit, so pin n lives in bit 31-n. A small two-state bus machine, `BUS_IDLE` and `BUS_RESP`, gives every read one cycle of latency. Any sampled read moves it to `BUS_RESP`, from either state. A cycle without a read moves it back to `BUS_IDLE`. `bus_rvalid` is high exactly while it is in `BUS_RESP`.

Top module: `gpio_edge_top`

## Requirements
- R1: After reset all six registers read zero, and `pin_oe`, `pin_out`, `pin_od`, `irq` and `bus_rvalid` are low.
- R2: Full-word accesses reach the registers at these byte offsets: 0x00 direction, 0x04 open-drain, 0x08 data, 0x0C event, 0x10 mask, 0x14 edge control. Any other offset reads zero, and a write to it changes nothing.
- R3: An access with `bus_full` low is narrow. A narrow read returns zero but still produces a `bus_rvalid` pulse. A narrow write changes no register.
- R4: Pin n corresponds to register bit 31-n. `pin_oe[n]` equals the direction bit, where 1 means output. `pin_out[n]` carries the data bit for output pins and is 0 for input pins. `pin_od[n]` equals the open-drain bit.
- R5: Writing the event register clears each event bit written as 1 and leaves every bit written as 0 unchanged.
- R6: `irq` is high exactly when the AND of event and mask is nonzero. It follows a register change with no further delay.
- R7: For an input pin whose edge control bit is 0, any level change sets its event bit. With the control bit at 1, only a high-to-low change sets it.
- R8: The data bit of an input pin mirrors the synchronised pin level, and data writes to input bits are ignored. A pin change driven just before clock edge 1 appears in the data and event registers after clock edge 3. Pin changes on output pins set no event and do not alter the data register.
- R9: If an edge sets an event bit in the same cycle that a write-one-to-clear targets that bit, the bit ends up set.
- R10: A read sampled on edge k presents `bus_rdata` and a one-cycle `bus_rvalid` pulse after edge k. Writes take effect on the edge that samples `bus_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_full | input | 1 | 1 = full 32-bit access, 0 = narrow access |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle per read |
| pin_in | input | 32 | Pin input levels, index = pin number |
| pin_out | output | 32 | Driven pin levels |
| pin_oe | output | 32 | Pin output enables |
| pin_od | output | 32 | Per-pin open-drain enables |
| irq | output | 1 | Combined interrupt |

## Verification
Results arrive at three different times:
- Register contents and `bus_rvalid` are due one cycle after the read strobe is sampled.
- `pin_out`, `pin_oe`, `pin_od` and `irq` follow a write on the edge that samples it.
- Pin edges reach the data and event registers on the third edge after the change.

The bench drives inputs on falling edges and samples on the falling edge after the cycle in which each result is due. It waits four edges after every pin change. The set-versus-clear collision needs exact timing, so the clearing write is placed on the third edge after the pin change, the edge on which the event is set.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] OFF_DIR = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_ODN = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_DAT = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_EVT = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_MSK = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_CTL = 8'h14;

    typedef enum logic {BUS_IDLE, BUS_RESP} bus_state_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      lvl,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      odn_q,
    output logic [W-1:0]      dat_q,
    output logic [W-1:0]      msk_q,
    output logic [W-1:0]      ctl_q
);
    logic [W-1:0] dat_out_nxt;

    always_comb begin
        dat_out_nxt = (wr_ok && addr == OFF_DAT) ? wdata : dat_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            odn_q <= '0;
            dat_q <= '0;
            msk_q <= '0;
            ctl_q <= '0;
        end else begin
            dat_q <= (dir_q & dat_out_nxt) | (~dir_q & lvl);
            if (wr_ok) begin
                case (addr)
                    OFF_DIR: dir_q <= wdata;
                    OFF_ODN: odn_q <= wdata;
                    OFF_MSK: msk_q <= wdata;
                    OFF_CTL: ctl_q <= wdata;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/gpio_evt.sv
module gpio_evt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] ctl_q,
    input  logic         clr_en,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] evt_q,
    output logic [W-1:0] set_vec
);
    logic [W-1:0] prev_q;
    logic [W-1:0] changed;
    logic [W-1:0] falling;
    logic [W-1:0] clr_vec;

    always_comb begin
        changed = lvl ^ prev_q;
        falling = prev_q & ~lvl;
        set_vec = ~dir_q & changed & (~ctl_q | falling);
        clr_vec = clr_en ? clr_mask : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            evt_q  <= '0;
        end else begin
            prev_q <= lvl;
            evt_q  <= (evt_q & ~clr_vec) | set_vec;
        end
    end
endmodule

// File: rtl/gpio_edge_top.sv
module gpio_edge_top
    import gpio_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_full,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic              bus_rvalid,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe,
    output logic [W-1:0]      pin_od,
    output logic              irq
);
    bus_state_e   state_q, state_nxt;
    logic         wr_ok, rd_ok, clr_en;
    logic [W-1:0] in_reg_order, lvl;
    logic [W-1:0] dir_q, odn_q, dat_q, msk_q, ctl_q, evt_q, set_vec;
    logic [W-1:0] rd_mux;

    assign wr_ok  = bus_wr & bus_full;
    assign rd_ok  = bus_rd & bus_full;
    assign clr_en = wr_ok && (bus_addr == OFF_EVT);

    for (genvar n = 0; n < W; n++) begin : g_pin
        assign in_reg_order[W-1-n] = pin_in[n];
        assign pin_oe[n]  = dir_q[W-1-n];
        assign pin_out[n] = dir_q[W-1-n] & dat_q[W-1-n];
        assign pin_od[n]  = odn_q[W-1-n];
    end

    gpio_sync #(.W(W)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(in_reg_order), .q(lvl)
    );

    gpio_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .addr(bus_addr),
        .wdata(bus_wdata), .lvl(lvl), .dir_q(dir_q), .odn_q(odn_q),
        .dat_q(dat_q), .msk_q(msk_q), .ctl_q(ctl_q)
    );

    gpio_evt #(.W(W)) u_evt (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .dir_q(dir_q), .ctl_q(ctl_q),
        .clr_en(clr_en), .clr_mask(bus_wdata), .evt_q(evt_q),
        .set_vec(set_vec)
    );

    assign irq = |(evt_q & msk_q);

    always_comb begin
        case (bus_addr)
            OFF_DIR: rd_mux = dir_q;
            OFF_ODN: rd_mux = odn_q;
            OFF_DAT: rd_mux = dat_q;
            OFF_EVT: rd_mux = evt_q;
            OFF_MSK: rd_mux = msk_q;
            OFF_CTL: rd_mux = ctl_q;
            default: rd_mux = '0;
        endcase
    end

    always_comb begin
        unique case (state_q)
            BUS_IDLE: state_nxt = bus_rd ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_nxt = bus_rd ? BUS_RESP : BUS_IDLE;
            default:  state_nxt = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_nxt;
    end

    always_comb begin
        bus_rvalid = (state_q == BUS_RESP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_ok ? rd_mux : '0;
    end
endmodule

// File: rtl/gpio_edge_chk.sv
module gpio_edge_chk
    import gpio_pkg::*;
#(
    parameter int W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              bus_full,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_wdata,
    input logic              bus_rvalid,
    input logic              irq,
    input logic [W-1:0]      dir_q,
    input logic [W-1:0]      msk_q,
    input logic [W-1:0]      evt_q,
    input logic [W-1:0]      set_vec
);
    // R10: a valid strobe only follows a sampled read
    a_r10_rvalid_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_rd));

    // R5: written ones clear unless an edge sets the bit again
    a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_full && bus_addr == OFF_EVT) |=>
        ((evt_q & $past(bus_wdata) & ~$past(set_vec)) == '0));

    // R8: output pins never gain a new event
    a_r8_no_output_event: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (((evt_q & ~$past(evt_q)) & $past(dir_q)) == '0));

    // R9: a detected edge always lands in the event register
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((evt_q & $past(set_vec)) == $past(set_vec)));

    // R6: no interrupt while every mask bit is clear
    a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (msk_q == '0) |-> !irq);
endmodule

bind gpio_edge_top gpio_edge_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_full(bus_full), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .irq(irq), .dir_q(dir_q), .msk_q(msk_q),
    .evt_q(evt_q), .set_vec(set_vec)
);

// File: tb/sim_gpio_edge_top.sv
module sim_gpio_edge_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_full = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata, pin_in = '0;
    logic [31:0] pin_out, pin_oe, pin_od;
    logic        bus_rvalid, irq;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    gpio_edge_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_full(bus_full), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_od(pin_od), .irq(irq)
    );

    // addr, write data, expected readback
    localparam logic [71:0] VEC [10] = '{
        {8'h00, 32'hA5A5_0F0F, 32'hA5A5_0F0F},
        {8'h04, 32'h1234_5678, 32'h1234_5678},
        {8'h10, 32'hFFFF_0000, 32'hFFFF_0000},
        {8'h14, 32'h0F0F_F0F0, 32'h0F0F_F0F0},
        {8'h18, 32'hFFFF_FFFF, 32'h0000_0000},
        {8'h1C, 32'h5555_5555, 32'h0000_0000},
        {8'h00, 32'h0000_0000, 32'h0000_0000},
        {8'h04, 32'h0000_0000, 32'h0000_0000},
        {8'h10, 32'h0000_0000, 32'h0000_0000},
        {8'h14, 32'h0000_0000, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic full = 1'b1);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_full = full;
        @(negedge clk);
        bus_wr = 1'b0; bus_full = 1'b1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, input logic full = 1'b1);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; bus_full = full;
        @(negedge clk);
        d = bus_rdata;
        check("R10 rvalid pulse", {31'd0, bus_rvalid}, 32'd1);
        bus_rd = 1'b0; bus_full = 1'b1;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 pin_oe", pin_oe, 32'h0);
        check("R1 pin_out", pin_out, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 outputs", {28'd0, irq, bus_rvalid, |pin_od, |pin_out}, 32'h0);
        for (int a = 0; a < 6; a++) begin
            rd(8'(a * 4), rv);
            check("R1 reg zero", rv, 32'h0);
        end

        // R2 table of register writes and readbacks
        for (int i = 0; i < 10; i++) begin
            wr(VEC[i][71:64], VEC[i][63:32]);
            rd(VEC[i][71:64], rv);
            check("R2 readback", rv, VEC[i][31:0]);
        end
        @(negedge clk);
        check("R10 rvalid drops", {31'd0, bus_rvalid}, 32'd0);

        // R2 unmapped write ignored
        wr(8'h00, 32'h0000_0001);
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h00, rv);
        check("R2 unmapped write ignored", rv, 32'h0000_0001);
        wr(8'h00, 32'h0);

        // R3 narrow accesses
        wr(8'h00, 32'hFFFF_FFFF, 1'b0);
        rd(8'h00, rv);
        check("R3 narrow write", rv, 32'h0);
        wr(8'h04, 32'h0000_00FF);
        rd(8'h04, rv, 1'b0);
        check("R3 narrow read", rv, 32'h0);
        rd(8'h04, rv);
        check("R3 full read", rv, 32'h0000_00FF);
        wr(8'h04, 32'h0);

        // R4 pin mapping, R8 input data bits
        wr(8'h00, 32'hC000_0000);
        wr(8'h08, 32'h8000_0001);
        wr(8'h04, 32'h0000_0001);
        @(negedge clk);
        check("R4 pin_oe", pin_oe, 32'h0000_0003);
        check("R4 pin_out", pin_out, 32'h0000_0001);
        check("R4 pin_od", pin_od, 32'h8000_0000);
        rd(8'h08, rv);
        check("R8 input data write ignored", rv, 32'h8000_0000);
        pin_in[31] = 1'b1;
        settle();
        rd(8'h08, rv);
        check("R8 input level mirrored", rv, 32'h8000_0001);
        pin_in[31] = 1'b0;
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h0);
        settle();
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, rv);
        check("R5 clear all", rv, 32'h0);

        // R7 any edge, R6 masking
        pin_in[5] = 1'b1;
        settle();
        rd(8'h0C, rv);
        check("R7 rise event", rv, 32'h0400_0000);
        check("R6 masked irq low", {31'd0, irq}, 32'd0);
        wr(8'h10, 32'h0400_0000);
        @(negedge clk);
        check("R6 unmasked irq high", {31'd0, irq}, 32'd1);
        wr(8'h0C, 32'hFBFF_FFFF);
        rd(8'h0C, rv);
        check("R5 zero bits kept", rv, 32'h0400_0000);
        wr(8'h0C, 32'h0400_0000);
        rd(8'h0C, rv);
        check("R5 one bit cleared", rv, 32'h0);
        check("R6 irq after clear", {31'd0, irq}, 32'd0);
        pin_in[5] = 1'b0;
        settle();
        rd(8'h0C, rv);
        check("R7 fall event any-edge", rv, 32'h0400_0000);
        wr(8'h0C, 32'hFFFF_FFFF);

        // R7 falling only
        wr(8'h14, 32'h0400_0000);
        pin_in[5] = 1'b1;
        settle();
        rd(8'h0C, rv);
        check("R7 rise ignored", rv, 32'h0);
        pin_in[5] = 1'b0;
        settle();
        rd(8'h0C, rv);
        check("R7 fall flagged", rv, 32'h0400_0000);
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h14, 32'h0);

        // R8 output pins ignore input
        wr(8'h00, 32'h2000_0000);
        pin_in[2] = 1'b1;
        settle();
        rd(8'h0C, rv);
        check("R8 output pin no event", rv, 32'h0);
        rd(8'h08, rv);
        check("R8 output pin data kept", rv, 32'h0);
        pin_in[2] = 1'b0;
        settle();
        wr(8'h00, 32'h0);

        // R9 edge set wins over same-cycle clear
        @(negedge clk);
        pin_in[7] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h0100_0000;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(8'h0C, rv);
        check("R9 set wins", rv, 32'h0100_0000);

        finish_run();
    end
endmodule